// File: doc/BRIEF.md
# Edge-Sensing GPIO Port

This block is an eight-pin general-purpose I/O port with a small register interface. Software picks, pin by pin, whether the pin drives (output) or listens (input), sets the value driven on output pins, and reads back the synchronized level of every pin. Any pin that is currently an input can raise an interrupt on a transition. Each pin has its own choice of rising or falling edge.

Pin levels are brought into the clock domain through a two-flop synchronizer. A third flop holds the previous synchronized level, and an edge is the difference between the two. A qualifying edge on an input pin whose interrupt is enabled sets a sticky pending bit. Software clears the bit by writing 1 to it. The pending bits, masked by the enables, are ORed into a single registered interrupt line.

The bus is a plain single-cycle register port. A write takes effect at the clock edge where `bus_we` is high. Read data is registered and appears one cycle after the address.

Top module: `gpio_edge_port`

## Requirements
- R1: After a synchronous reset every pin is an input (`pin_oe` = 0x00). `pin_out`, direction, polarity (all rising), interrupt enables and pending bits are all 0, and `irq` is 0.
- R2: Writing address 0 sets the direction register. Bit i = 1 makes pin i an output. `pin_oe` equals this register from the edge after the write.
- R3: Writing address 1 sets the output data register. `pin_out` equals this register from the edge after the write.
- R4: Reading address 2 returns the two-flop synchronized pin levels. A write to address 2 changes no register.
- R5: With polarity bit i = 0 (address 3), a low-to-high transition on input pin i sets pending bit i two clock edges after the first edge that samples the new level.
- R6: With polarity bit i = 1, a high-to-low transition on pin i sets pending bit i, and a low-to-high transition does not.
- R7: A pin whose direction bit is 1 never sets its pending bit, whatever its pin level does.
- R8: A pin whose interrupt enable bit (address 4) is 0 never sets its pending bit.
- R9: Pending bits (address 5) are sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. If an edge sets a bit in the same cycle a write clears it, the set wins.
- R10: `irq` is the registered OR of (pending AND enable). It follows that expression with one cycle of delay.
- R11: Changing direction or polarity while pin levels stay constant sets no pending bit.
- R12: `bus_rdata` holds the register selected by `bus_addr` one cycle earlier. Addresses 6 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_out | output | 8 | Output data to pins |
| pin_oe | output | 8 | Output enable per pin (1 = drive) |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench toggles pin levels and compares against a behavioural model every cycle. It targets the following corner cases:
- A clear write that lands in the same cycle as a new edge. A design where clear wins would lose that event.
- A rising edge with falling polarity selected. A design that ignores polarity would set a pending bit here.
- Toggling output-direction and disabled pins. A design that leaks these would show spurious pending bits.
- Flipping polarity and direction while pins are still. A design that derives edges from the configuration would report a phantom event.
- Masking a pending bit by clearing its enable. `irq` must drop one cycle later while the pending bit remains readable.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    REG_DIR  = 3'd0,
    REG_DOUT = 3'd1,
    REG_DIN  = 3'd2,
    REG_POL  = 3'd3,
    REG_IEN  = 3'd4,
    REG_PEND = 3'd5
  } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
// Multi-stage synchronizer plus one history flop for edge detection.
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] level,
  output logic [W-1:0] level_prev
);
  localparam int DEPTH = STAGES + 1;

  logic [W-1:0] chain [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) chain[i] <= '0;
    end else begin
      chain[0] <= async_in;
      for (int i = 1; i < DEPTH; i++) chain[i] <= chain[i-1];
    end
  end

  assign level      = chain[STAGES-1];
  assign level_prev = chain[STAGES];
endmodule

// File: rtl/gpio_edge_detect.sv
// Per-pin edge qualification: polarity select, input-only, enable gate.
module gpio_edge_detect #(
  parameter int W = 8
) (
  input  logic [W-1:0] level,
  input  logic [W-1:0] level_prev,
  input  logic [W-1:0] fall_sel,
  input  logic [W-1:0] is_output,
  input  logic [W-1:0] enable,
  output logic [W-1:0] hit
);
  for (genvar g = 0; g < W; g++) begin : g_pin
    logic rise_g, fall_g, edge_g;
    assign rise_g  =  level[g] & ~level_prev[g];
    assign fall_g  = ~level[g] &  level_prev[g];
    assign edge_g  = fall_sel[g] ? fall_g : rise_g;
    assign hit[g]  = edge_g & ~is_output[g] & enable[g];
  end
endmodule

// File: rtl/gpio_regs.sv
// Register file, sticky pending bits, interrupt combine and read mux.
module gpio_regs
  import gpio_edge_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [W-1:0]      bus_wdata,
  input  logic [W-1:0]      din,
  input  logic [W-1:0]      hit,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      dout_q,
  output logic [W-1:0]      pol_q,
  output logic [W-1:0]      ien_q,
  output logic [W-1:0]      pend_q,
  output logic [W-1:0]      rdata_q,
  output logic              irq_q
);
  logic [W-1:0] clr;
  logic [W-1:0] rd_mux;

  assign clr = (bus_we && bus_addr == REG_PEND) ? bus_wdata : '0;

  always_comb begin
    case (bus_addr)
      REG_DIR:  rd_mux = dir_q;
      REG_DOUT: rd_mux = dout_q;
      REG_DIN:  rd_mux = din;
      REG_POL:  rd_mux = pol_q;
      REG_IEN:  rd_mux = ien_q;
      REG_PEND: rd_mux = pend_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= '0;
      dout_q  <= '0;
      pol_q   <= '0;
      ien_q   <= '0;
      pend_q  <= '0;
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (bus_we) begin
        case (bus_addr)
          REG_DIR:  dir_q  <= bus_wdata;
          REG_DOUT: dout_q <= bus_wdata;
          REG_POL:  pol_q  <= bus_wdata;
          REG_IEN:  ien_q  <= bus_wdata;
          default: ;
        endcase
      end
      pend_q  <= (pend_q & ~clr) | hit;
      irq_q   <= |(pend_q & ien_q);
      rdata_q <= rd_mux;
    end
  end
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_edge_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  logic [NPINS-1:0] level, level_prev, hit;
  logic [NPINS-1:0] dir_q, dout_q, pol_q, ien_q, pend_q;

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(pin_in),
    .level(level), .level_prev(level_prev)
  );

  gpio_edge_detect #(.W(NPINS)) u_edge (
    .level(level), .level_prev(level_prev), .fall_sel(pol_q),
    .is_output(dir_q), .enable(ien_q), .hit(hit)
  );

  gpio_regs #(.W(NPINS)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .din(level), .hit(hit),
    .dir_q(dir_q), .dout_q(dout_q), .pol_q(pol_q), .ien_q(ien_q),
    .pend_q(pend_q), .rdata_q(bus_rdata), .irq_q(irq)
  );

  assign pin_oe  = dir_q;
  assign pin_out = dout_q;
endmodule

// File: rtl/gpio_edge_port_sva.sv
module gpio_edge_port_sva
  import gpio_edge_pkg::*;
#(
  parameter int W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [REG_AW-1:0] bus_addr,
  input logic              bus_we,
  input logic [W-1:0]      bus_wdata,
  input logic [W-1:0]      pin_out,
  input logic [W-1:0]      pin_oe,
  input logic              irq,
  input logic [W-1:0]      pend,
  input logic [W-1:0]      ien
);
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pin_oe == '0 && pin_out == '0 && !irq && pend == '0));

  a_r2_dir_write: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == REG_DIR) |=> (pin_oe == $past(bus_wdata)));

  a_r3_dout_write: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == REG_DOUT) |=> (pin_out == $past(bus_wdata)));

  a_r7_output_no_pend: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend & ~$past(pend) & $past(pin_oe)) == '0));

  a_r8_disabled_no_pend: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(ien)) == '0));

  a_r10_irq_combine: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == (|($past(pend) & $past(ien)))));
endmodule

bind gpio_edge_port gpio_edge_port_sva #(.W(NPINS)) u_sva (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .pin_out(pin_out), .pin_oe(pin_oe),
  .irq(irq), .pend(pend_q), .ien(ien_q)
);

// File: tb/gpio_edge_port_bench.sv
module gpio_edge_port_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out, pin_oe;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit started = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_edge_port u_gpio_edge_port (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // Behavioural reference model
  logic [7:0] m_dir, m_dout, m_pol, m_ien, m_pend, m_rdata;
  logic       m_irq;
  logic [7:0] hist[$];

  always @(posedge clk) begin
    logic [7:0] cur, prv, rise, fall, hitv, clrv, rd;
    if (rst) begin
      m_dir = 0; m_dout = 0; m_pol = 0; m_ien = 0; m_pend = 0;
      m_rdata = 0; m_irq = 0;
      hist = '{8'h00, 8'h00, 8'h00};
    end else begin
      cur  = hist[1];
      prv  = hist[2];
      rise = cur & ~prv;
      fall = ~cur & prv;
      hitv = ((m_pol & fall) | (~m_pol & rise)) & ~m_dir & m_ien;
      clrv = (bus_we && bus_addr == 3'd5) ? bus_wdata : 8'h00;
      case (bus_addr)
        3'd0: rd = m_dir;
        3'd1: rd = m_dout;
        3'd2: rd = cur;
        3'd3: rd = m_pol;
        3'd4: rd = m_ien;
        3'd5: rd = m_pend;
        default: rd = 8'h00;
      endcase
      m_irq   = |(m_pend & m_ien);
      m_rdata = rd;
      m_pend  = (m_pend & ~clrv) | hitv;
      if (bus_we) begin
        if (bus_addr == 3'd0) m_dir  = bus_wdata;
        if (bus_addr == 3'd1) m_dout = bus_wdata;
        if (bus_addr == 3'd3) m_pol  = bus_wdata;
        if (bus_addr == 3'd4) m_ien  = bus_wdata;
      end
      hist.push_front(pin_in);
      void'(hist.pop_back());
    end
    started = 1;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (started && !done) begin
      chk("R2 pin_oe vs model", pin_oe, m_dir);
      chk("R3 pin_out vs model", pin_out, m_dout);
      chk("R10 irq vs model", {7'b0, irq}, {7'b0, m_irq});
      chk("R12 rdata vs model", bus_rdata, m_rdata);
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R1 reset state
    chk("R1 pin_oe", pin_oe, 8'h00);
    chk("R1 pin_out", pin_out, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    rd(3'd3, v); chk("R1 polarity", v, 8'h00);
    rd(3'd4, v); chk("R1 enables", v, 8'h00);
    rd(3'd5, v); chk("R1 pending", v, 8'h00);

    // R2 / R3 direction and output data
    wr(3'd0, 8'hF0);
    chk("R2 pin_oe", pin_oe, 8'hF0);
    wr(3'd1, 8'hA5);
    chk("R3 pin_out", pin_out, 8'hA5);
    rd(3'd0, v); chk("R2 readback", v, 8'hF0);
    wr(3'd0, 8'h00);

    // R4 synchronized input and read-only address
    pin_in = 8'h3C; cyc(3);
    rd(3'd2, v); chk("R4 din", v, 8'h3C);
    wr(3'd2, 8'hFF);
    rd(3'd2, v); chk("R4 din after write", v, 8'h3C);
    rd(3'd1, v); chk("R4 dout untouched", v, 8'hA5);
    rd(3'd0, v); chk("R4 dir untouched", v, 8'h00);

    // R5 rising edge
    wr(3'd4, 8'hFF);
    pin_in = 8'h3D; cyc(4);
    rd(3'd5, v); chk("R5 rising pend", v, 8'h01);
    chk("R10 irq high", {7'b0, irq}, 8'h01);

    // R9 write 0 ignored, write 1 clears
    wr(3'd5, 8'h00);
    rd(3'd5, v); chk("R9 write0 keeps", v, 8'h01);
    wr(3'd5, 8'h01);
    rd(3'd5, v); chk("R9 write1 clears", v, 8'h00);
    chk("R10 irq low", {7'b0, irq}, 8'h00);

    // R6 falling polarity on pin 2
    wr(3'd3, 8'h04);
    pin_in = 8'h39; cyc(4);
    rd(3'd5, v); chk("R6 falling pend", v, 8'h04);
    wr(3'd5, 8'hFF);
    pin_in = 8'h3D; cyc(4);
    rd(3'd5, v); chk("R6 rising ignored", v, 8'h00);

    // R7 output pin toggling
    wr(3'd0, 8'h08);
    pin_in = 8'h35; cyc(4);
    rd(3'd5, v); chk("R7 output fall", v, 8'h00);
    pin_in = 8'h3D; cyc(4);
    rd(3'd5, v); chk("R7 output rise", v, 8'h00);
    wr(3'd0, 8'h00);
    cyc(2);

    // R8 disabled pin
    wr(3'd4, 8'hFE);
    pin_in = 8'h3C; cyc(4);
    pin_in = 8'h3D; cyc(4);
    rd(3'd5, v); chk("R8 disabled pin", v, 8'h00);
    chk("R8 irq", {7'b0, irq}, 8'h00);

    // R11 config changes with stable pins
    wr(3'd3, 8'hFF);
    wr(3'd0, 8'hFF);
    wr(3'd0, 8'h00);
    wr(3'd3, 8'h00);
    cyc(4);
    rd(3'd5, v); chk("R11 no phantom", v, 8'h00);

    // R9 set wins over same-cycle clear
    wr(3'd4, 8'hFF);
    pin_in = 8'h7D;
    cyc(2);
    wr(3'd5, 8'h40);
    rd(3'd5, v); chk("R9 set wins", v, 8'h40);
    wr(3'd5, 8'hFF);
    rd(3'd5, v); chk("R9 clear all", v, 8'h00);

    // R10 masking by enable
    pin_in = 8'hFD; cyc(4);
    chk("R10 irq from pin7", {7'b0, irq}, 8'h01);
    wr(3'd4, 8'h7F);
    cyc(1);
    chk("R10 irq masked", {7'b0, irq}, 8'h00);
    rd(3'd5, v); chk("R10 pending kept", v, 8'h80);

    // R12 unmapped addresses
    rd(3'd6, v); chk("R12 addr6", v, 8'h00);
    rd(3'd7, v); chk("R12 addr7", v, 8'h00);

    cyc(2);
    finish_run();
  end
endmodule